// File: doc/BRIEF.md
# Reloading Interval Down-Counter

This block is an interval timer whose count register steps downward once for every count-enable pulse. When a pulse arrives while the count is already zero, the count is refilled from a separate, software-writable base register and a one-clock interrupt request is raised. The interrupt therefore recurs once every base+1 count pulses. The count events come from outside the block, so any prescaler or clock-source choice is made elsewhere.

Software uses a small byte-wide register port with a two-bit offset. Through it, software writes the base value, reads back the base value, reads the live count, and sets or clears a load-enable control bit. While load-enable is set, the counter copies the base value on every clock, ignores count pulses and raises no interrupt. Software normally sets load-enable for a cycle to start a fresh interval. A base value written while the timer is running leaves the live count alone and is used at the next reload.

Top module: `rdt_timer`

## Requirements
- R1: After reset the base register, the count and the load-enable bit read 0, and `irq_out` is low.
- R2: Offset 0 is the base register and offset 2 the control register, both read/write. Bit 0 of the control register is load-enable, and control bits 7..1 always read 0.
- R3: The count can be read at offset 1. A write to offset 1 leaves the count unchanged.
- R4: A read of offset 3 returns 0, and a write to offset 3 changes no register.
- R5: A count pulse while load-enable is clear and the count is not zero lowers the count by exactly one at the next clock, with `irq_out` low.
- R6: A count pulse while load-enable is clear and the count is zero loads the base value into the count. On the next clock `irq_out` is high, for that one clock only.
- R7: After a load, underflow interrupts recur exactly once every base+1 count pulses.
- R8: While load-enable reads 1, the count takes the base value at every clock, count pulses are ignored and `irq_out` stays low.
- R9: With a base value of 0, every count pulse raises the interrupt.
- R10: Writing the base register while the timer counts does not alter the live count. The new value is taken at the next reload.
- R11: In a clock with neither a count pulse nor load-enable, the count holds and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| cnt_tick | input | 1 | Count-enable pulse, one step per clock in which it is high |
| irq_out | output | 1 | One-clock underflow interrupt request |

## Verification
On every clock the assertions check the step from one count value to the next. This covers a decrement, a reload together with the interrupt on underflow, a copy of the base value under load-enable, and holding with the interrupt low when idle. They also check the read path for the count and for the unmapped offset. The interval length itself (base+1 pulses, and base 0 interrupting on every pulse) only shows over a run of many pulses. The same holds for a base value written in mid-interval taking effect one reload later. So the bench sweeps base values and counts interrupt spacing against an arithmetic model.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  // Register offsets on the byte port; the read mux decodes these.
  typedef enum logic [1:0] {
    OFS_BASE  = 2'd0,
    OFS_COUNT = 2'd1,
    OFS_CTRL  = 2'd2,
    OFS_NONE  = 2'd3
  } reg_ofs_e;

  // Bit position of load-enable inside the control register.
  localparam int unsigned CTRL_LDE_BIT = 0;
endpackage

// File: rtl/rdt_regs.sv
module rdt_regs
  import rdt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wen,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] base_q,
  output logic         lde_q
);
  logic base_sel;
  logic ctrl_sel;

  assign base_sel = wen && (reg_ofs_e'(addr) == OFS_BASE);
  assign ctrl_sel = wen && (reg_ofs_e'(addr) == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_sel) begin
      base_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lde_q <= 1'b0;
    end else if (ctrl_sel) begin
      lde_q <= wdata[CTRL_LDE_BIT];
    end
  end
endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         lde,
  input  logic [W-1:0] base,
  output logic [W-1:0] count_q,
  output logic         irq_q,
  output logic         uf_evt,
  output logic         ld_evt
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  // True when a pulse finds the count exhausted.
  function automatic logic is_underflow(input logic t, input logic l,
                                        input logic [W-1:0] c);
    return t && !l && (c == ZERO);
  endfunction

  // Next count value given the pulse, load-enable and base.
  function automatic logic [W-1:0] next_count(input logic t, input logic l,
                                               input logic [W-1:0] c,
                                               input logic [W-1:0] b);
    if (l) return b;
    if (!t) return c;
    if (c == ZERO) return b;
    return c - ONE;
  endfunction

  logic [W-1:0] count_d;

  assign uf_evt  = is_underflow(tick, lde, count_q);
  assign ld_evt  = lde;
  assign count_d = next_count(tick, lde, count_q, base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      irq_q   <= uf_evt;
    end
  end
endmodule

// File: rtl/rdt_rdmux.sv
module rdt_rdmux
  import rdt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [1:0]   addr,
  input  logic [W-1:0] base,
  input  logic [W-1:0] count,
  input  logic         lde,
  output logic [W-1:0] rdata
);
  logic [W-1:0] ctrl_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_LDE_BIT] = lde;
  end

  always_comb begin
    unique case (reg_ofs_e'(addr))
      OFS_BASE:  rdata = base;
      OFS_COUNT: rdata = count;
      OFS_CTRL:  rdata = ctrl_word;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/rdt_timer.sv
module rdt_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wen,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         cnt_tick,
  output logic         irq_out
);
  logic [W-1:0] base_w;
  logic         lde_w;
  logic [W-1:0] count_w;
  logic         uf_w;
  logic         ld_w;

  rdt_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wen    (reg_wen),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .base_q (base_w),
    .lde_q  (lde_w)
  );

  rdt_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_tick),
    .lde     (lde_w),
    .base    (base_w),
    .count_q (count_w),
    .irq_q   (irq_out),
    .uf_evt  (uf_w),
    .ld_evt  (ld_w)
  );

  rdt_rdmux #(.W(W)) u_mux (
    .addr  (reg_addr),
    .base  (base_w),
    .count (count_w),
    .lde   (lde_w),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/rdt_timer_chk.sv
module rdt_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_tick,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_rdata,
  input logic         irq_out,
  input logic [W-1:0] base_w,
  input logic         lde_w,
  input logic [W-1:0] count_w,
  input logic         uf_w,
  input logic         ld_w
);
  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !lde_w && count_w != '0) |=>
      (count_w == W'($past(count_w) - W'(1)) && !irq_out));

  assert_reload_on_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !lde_w && count_w == '0) |=>
      (count_w == $past(base_w) && irq_out));

  assert_irq_from_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !uf_w |=> !irq_out);

  assert_load_copies_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_w |=> (count_w == $past(base_w) && !irq_out));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !lde_w) |=> ($stable(count_w) && !irq_out));

  assert_count_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata == count_w));

  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

bind rdt_timer rdt_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_tick  (cnt_tick),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .base_w    (base_w),
  .lde_w     (lde_w),
  .count_w   (count_w),
  .uf_w      (uf_w),
  .ld_w      (ld_w)
);

// File: tb/sim_rdt_timer.sv
module sim_rdt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wen = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       cnt_tick = 1'b0;
  logic       irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rdt_timer #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_tick(cnt_tick),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #0.5;
    v = int'(reg_rdata);
  endtask

  // one pulse; returns sampled count and irq after the edge
  task automatic pulse(output int c, output int i);
    @(negedge clk);
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
    i = int'(irq_out);
    rd(2'd1, c);
  endtask

  task automatic load(input int b);
    wr(2'd0, 8'(b));
    wr(2'd2, 8'd1);
    wr(2'd2, 8'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, c, i, irqs, k;
    #1;
    // R1 reset state
    rd(2'd0, v); check("R1 base", v, 0);
    rd(2'd1, v); check("R1 count", v, 0);
    rd(2'd2, v); check("R1 ctrl", v, 0);
    check("R1 irq", int'(irq_out), 0);
    #7 rst_n = 1'b1;

    // R2 register read/write; ctrl upper bits read 0
    wr(2'd0, 8'hA5); rd(2'd0, v); check("R2 base rw", v, 8'hA5);
    wr(2'd2, 8'hFE); rd(2'd2, v); check("R2 ctrl upper bits", v, 0);
    wr(2'd2, 8'hFF); rd(2'd2, v); check("R2 ctrl lde", v, 1);
    @(negedge clk); rd(2'd1, v); check("R8 count follows base", v, 8'hA5);
    // R8 pulses ignored under load-enable
    @(negedge clk); cnt_tick = 1'b1;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      rd(2'd1, v); check("R8 count held at base", v, 8'hA5);
      check("R8 no irq", int'(irq_out), 0);
    end
    cnt_tick = 1'b0;
    wr(2'd0, 8'h3C); @(negedge clk);
    rd(2'd1, v); check("R8 tracks new base", v, 8'h3C);
    wr(2'd2, 8'h00); rd(2'd2, v); check("R2 ctrl clear", v, 0);

    // R3 write to count offset ignored; R4 offset 3
    wr(2'd1, 8'h55); rd(2'd1, v); check("R3 count read-only", v, 8'h3C);
    wr(2'd3, 8'h77); rd(2'd3, v); check("R4 unmapped reads 0", v, 0);
    rd(2'd0, v); check("R4 base untouched", v, 8'h3C);
    rd(2'd2, v); check("R4 ctrl untouched", v, 0);

    // R11 idle holds
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R11 idle hold", v, 8'h3C);
    check("R11 idle irq low", int'(irq_out), 0);

    // R5 R6 R7 R9 sweep of base values
    for (int b = 0; b < 130; b++) begin
      int bb;
      bb = (b < 128) ? b : ((b == 128) ? 200 : 255);
      load(bb);
      irqs = 0;
      for (k = 1; k <= 2 * (bb + 1); k++) begin
        pulse(c, i);
        irqs += i;
        if (k % (bb + 1) == 0) begin
          check(bb == 0 ? "R9 irq each pulse" : "R6 underflow irq", i, 1);
          check("R6 reload", c, bb);
        end else begin
          check("R5 decrement", c, bb - (k % (bb + 1)));
          check("R5 irq low", i, 0);
        end
      end
      check("R7 irq count over two intervals", irqs, 2);
      @(negedge clk);
      check("R6 irq one clock", int'(irq_out), 0);
    end

    // R10 base write mid-interval
    load(10);
    for (int n = 0; n < 3; n++) pulse(c, i);
    wr(2'd0, 8'd4);
    rd(2'd1, v); check("R10 count unchanged", v, 7);
    for (int n = 0; n < 7; n++) pulse(c, i);
    check("R10 reached zero", c, 0);
    pulse(c, i);
    check("R10 new base at reload", c, 4);
    check("R10 irq", i, 1);
    irqs = 0;
    for (int n = 0; n < 10; n++) begin pulse(c, i); irqs += i; end
    check("R10 new period", irqs, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule